// File: doc/BRIEF.md
# Six-Source Maskable Interrupt Controller

This block gathers six event sources from a measurement front end into sticky flag registers. It raises a single active-low interrupt request whenever a flag whose enable bit is set is high. The host reads the flag bits on a status output to find the cause. It clears any chosen subset of flags in one operation by pulling a clear strobe low while the data bus carries a one in each bit it wants cleared.

Each source is qualified before it can set its flag. A trigger counts only while the arm input is held low. A marker completion counts only in free-run mode. The main-block flag waits until both channels have reported completion, in either order or together. The enable mask is loaded from the data bus with a write strobe, and it has no read path.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, status is 6'b000000, every enable bit is 0, and irq_n is 1.
- R2: Status bit 0 (trigger) sets after a clock edge where trig_evt is 1 and arm_n is 0. A trigger sampled while arm_n is 1 leaves bit 0 unchanged.
- R3: Status bit 1 (marker) sets after an edge where mark_done is 1 and freerun is 1. A mark_done pulse sampled while freerun is 0 has no effect.
- R4: Status bit 2 (main block) sets at the edge where the second of the two channels reports completion on ch_done[1:0]. The two reports may come in either order or in the same cycle. Once bit 2 sets, both channel reports are forgotten, and a fresh pair is needed to set it again.
- R5: Status bits 3, 4 and 5 set after an edge where aux2_full, aux1_full or in_empty, respectively, is 1.
- R6: A set flag stays set until it is cleared, whatever its source does afterwards.
- R7: At an edge with clr_n at 0, every flag whose dbus bit is 1 is cleared, and flags whose dbus bit is 0 are kept.
- R8: If a flag's qualified set and its clear fall on the same edge, the flag ends up set.
- R9: At an edge with mask_we at 1, the enable mask takes the value of dbus. irq_n is 0 exactly when some status bit and its enable bit are both 1.
- R10: A flag whose enable bit is 0 still sets and still shows on status, but it does not pull irq_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_n | input | 1 | Active-low arm window for the trigger source |
| trig_evt | input | 1 | Trigger event pulse |
| freerun | input | 1 | Free-run measurement mode |
| mark_done | input | 1 | Marker count finished pulse |
| ch_done | input | 2 | Per-channel main data block complete pulses |
| aux2_full | input | 1 | Auxiliary block 2 full pulse |
| aux1_full | input | 1 | Filtered auxiliary block 1 full pulse |
| in_empty | input | 1 | Input data block emptied pulse |
| mask_we | input | 1 | Load the enable mask from dbus |
| clr_n | input | 1 | Active-low clear strobe, qualified per bit by dbus |
| dbus | input | 6 | Host data bus for mask writes and clear patterns |
| status | output | 6 | Flag status latch |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag's qualified set and its selective clear can land on the same clock edge. This is the case where an event could be lost. The bench forces the collision directly, asserting every source together with clr_n low and dbus all ones, and it confirms that every flag reads set afterwards. The random phase also produces such collisions often, and a cycle-accurate bench model scores each one. Collisions between a mask write and a newly set flag are judged on irq_n in the cycle after the edge.

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int NFLAG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_n,
  input  logic             trig_evt,
  input  logic             freerun,
  input  logic             mark_done,
  input  logic [1:0]       ch_done,
  input  logic             aux2_full,
  input  logic             aux1_full,
  input  logic             in_empty,
  input  logic             mask_we,
  input  logic             clr_n,
  input  logic [NFLAG-1:0] dbus,
  output logic [NFLAG-1:0] status,
  output logic             irq_n
);
  logic [NFLAG-1:0] flags, mask, set_vec, clr_vec;
  logic [1:0]       seen;
  logic [1:0]       seen_nx;
  logic             both_done;

  assign seen_nx   = seen | ch_done;
  assign both_done = &seen_nx;

  assign set_vec = {in_empty, aux1_full, aux2_full, both_done,
                    mark_done & freerun, trig_evt & ~arm_n};
  assign clr_vec = clr_n ? '0 : dbus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
      seen  <= '0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
      seen  <= both_done ? 2'b00 : seen_nx;
      if (mask_we) mask <= dbus;
    end
  end

  assign status = flags;
  assign irq_n  = ~|(flags & mask);
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int NFLAG = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_n,
  input logic             trig_evt,
  input logic             freerun,
  input logic             mark_done,
  input logic             aux2_full,
  input logic             aux1_full,
  input logic             in_empty,
  input logic             clr_n,
  input logic [NFLAG-1:0] dbus,
  input logic [NFLAG-1:0] status,
  input logic             irq_n
);
  logic [NFLAG-1:0] kept;
  assign kept = status & ~(clr_n ? '0 : dbus);

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(kept)) == $past(kept)));

  // R2
  trig_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && arm_n && !status[0]) |=> !status[0]);

  // R8
  trig_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && !arm_n) |=> status[0]);

  // R3
  marker_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_done && !freerun && !status[1]) |=> !status[1]);

  // R5
  aux_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux2_full && aux1_full && in_empty) |=> (status[5:3] == 3'b111));

  // R10
  always_comb if (rst_n) quiet_irq_chk: assert (status != '0 || irq_n);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NFLAG(NFLAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_n(arm_n), .trig_evt(trig_evt),
  .freerun(freerun), .mark_done(mark_done), .aux2_full(aux2_full),
  .aux1_full(aux1_full), .in_empty(in_empty), .clr_n(clr_n),
  .dbus(dbus), .status(status), .irq_n(irq_n)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
  logic       clk = 0, rst_n = 0;
  logic       arm_n = 1, trig_evt = 0, freerun = 0, mark_done = 0;
  logic [1:0] ch_done = 0;
  logic       aux2_full = 0, aux1_full = 0, in_empty = 0, mask_we = 0, clr_n = 1;
  logic [5:0] dbus = 0, status;
  logic       irq_n;
  int         tests = 0, fails = 0;
  bit         done = 0;
  logic [5:0] m_flags = 0, m_mask = 0;
  logic [1:0] m_seen = 0;

  always #4 clk = ~clk;

  evt_irq_ctrl u_evt_irq_ctrl (.*);

  function automatic logic [5:0] setv(logic [1:0] sn);
    logic [1:0] s = sn | ch_done;
    return {in_empty, aux1_full, aux2_full, &s, mark_done & freerun, trig_evt & ~arm_n};
  endfunction

  function automatic logic exp_irq(logic [5:0] f, logic [5:0] m);
    return !(|(f & m));
  endfunction

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {irq_n,status} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [1:0] s = m_seen | ch_done;
    logic [5:0] c = clr_n ? 6'b0 : dbus;
    m_flags = (m_flags & ~c) | setv(m_seen);
    m_seen  = (&s) ? 2'b00 : s;
    if (mask_we) m_mask = dbus;
    @(posedge clk); #1;
    chk(tag, {irq_n, status}, {exp_irq(m_flags, m_mask), m_flags});
    @(negedge clk);
    {trig_evt, mark_done, ch_done, aux2_full, aux1_full, in_empty, mask_we} = '0;
    clr_n = 1; arm_n = 1; freerun = 0; dbus = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #1 chk("R1 reset", {irq_n, status}, 7'b1000000);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {irq_n, status}, 7'b1000000);
    mask_we = 1; dbus = 6'h3f; step("R9 mask write all");
    trig_evt = 1; arm_n = 1; step("R2 unarmed trigger ignored");
    trig_evt = 1; arm_n = 0; step("R2 armed trigger");
    mark_done = 1; freerun = 0; step("R3 marker outside free-run ignored");
    mark_done = 1; freerun = 1; step("R3 marker in free-run");
    ch_done = 2'b10; step("R4 first channel only");
    ch_done = 2'b10; step("R4 same channel again");
    ch_done = 2'b01; step("R4 second channel sets");
    clr_n = 0; dbus = 6'b000100; step("R7 clear main only");
    ch_done = 2'b01; step("R4 pair forgotten after set");
    aux2_full = 1; aux1_full = 1; in_empty = 1; step("R5 aux and empty");
    step("R6 sticky idle");
    clr_n = 0; dbus = 6'b101010; step("R7 selective clear");
    trig_evt = 1; arm_n = 0; mark_done = 1; freerun = 1; ch_done = 2'b11;
    aux2_full = 1; aux1_full = 1; in_empty = 1; clr_n = 0; dbus = 6'h3f;
    step("R8 set wins over clear");
    mask_we = 1; dbus = 6'b000000; step("R10 masked flags still show");
    clr_n = 0; dbus = 6'h3f; step("R7 clear all");
    mask_we = 1; dbus = 6'b010000; step("R9 mask single");
    in_empty = 1; step("R10 masked source sets no irq");
    aux1_full = 1; step("R9 enabled source pulls irq");
    for (int i = 0; i < 2000; i++) begin
      arm_n = $urandom_range(0, 1); trig_evt = ($urandom_range(0, 3) == 0);
      freerun = $urandom_range(0, 1); mark_done = ($urandom_range(0, 3) == 0);
      ch_done = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
      aux2_full = ($urandom_range(0, 5) == 0); aux1_full = ($urandom_range(0, 5) == 0);
      in_empty = ($urandom_range(0, 5) == 0);
      clr_n = ($urandom_range(0, 3) != 0); mask_we = ($urandom_range(0, 7) == 0);
      dbus = 6'($urandom);
      step("R6 R7 R8 R9 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule